// File: doc/BRIEF.md
# PCI Command and Status Configuration Registers

This block keeps the 16-bit command word and the 16-bit status word of one PCI function. Both share one configuration dword. The command word sits in bytes 0–1 and the status word in bytes 2–3. Upstream logic has already decoded the address, so every request this block receives targets that dword. A write is qualified per byte lane by its byte enables. A read returns the whole dword.

The bus-interface logic reports four kinds of event to the block as single-cycle pulses:
- the function generated a master-abort;
- the function received a target-abort while acting as master;
- the function ended an access aimed at it with a target-abort;
- a delayed transaction timed out.

The block records these events in sticky status flags. Software clears a flag by writing 1 to it. A timeout is turned into a one-cycle system-error request only when both the local enable and an external control bit allow it.

The block also gates a "shutdown special cycle seen" indication with the special-cycle enable. It drives the command enables as plain control outputs to the rest of the bridge.

Requests enter on a valid/ready channel. Read data leaves on a second valid/ready channel that holds one response.
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low while a response is pending and `rsp_ready` is low.
- Once `rsp_valid` is high, it and `rsp_rdata` stay unchanged until `rsp_ready` is seen high.

Top module: `pci_cmdsts_regs`

## Requirements
- R1: After reset, a read returns 0x0280_0007. That is, the command word is 0x0007 and the status word is 0x0280.
- R2: Command bits 2:0 (I/O space, memory space, bus master) always read 1, and writes do not change them. Command bits 4, 7:5, 9 and 15:10 always read 0. The outputs `io_en`, `mem_en` and `bus_master_en` stay high.
- R3: Command bit 3 (dword bit 3, byte enable 0) is the special-cycle enable. `shutdown_hit` follows `spc_shutdown` in the same cycle when the enable is 1, and stays 0 when it is 0.
- R4: Command bit 8 (dword bit 8, byte enable 1) is the error-report enable. Lanes 0 and 1 are written independently: a write with only one of those enables set leaves the other lane's bit unchanged.
- R5: `serr_req` is a one-cycle pulse in the cycle after a `dt_timeout` pulse. It appears only when command bit 8 is 1 and `serr_ext_en` is 1; otherwise no pulse appears.
- R6: Status bit 14 (dword bit 30) becomes 1 in the same cycle that `serr_req` is high.
- R7: Status bit 13 (dword bit 29) sets on `ev_master_abort`. Status bit 12 (dword bit 28) sets on `ev_target_abort_rcvd`. Status bit 11 (dword bit 27) sets on `ev_target_abort_sent`.
- R8: Status bits 14:11 are cleared by writing 1 to them with byte enable 3 set. A 0 written to one of these bits leaves it unchanged. A write with byte enable 3 clear does not affect them.
- R9: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: Status bits 10:9 always read 01 and status bit 7 always reads 1. Status bits 15, 8 and 6:0 always read 0. Writes change none of these bits.
- R11: A read is answered with `rsp_valid` in the cycle after it is accepted. The data is the register contents before that edge. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Config request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for a write |
| req_wdata | input | 32 | Write data (command low half, status high half) |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| ev_master_abort | input | 1 | Pulse: master-abort generated |
| ev_target_abort_rcvd | input | 1 | Pulse: target-abort received as master |
| ev_target_abort_sent | input | 1 | Pulse: target-abort signalled as target |
| dt_timeout | input | 1 | Pulse: delayed transaction timed out |
| serr_ext_en | input | 1 | External system-error reporting enable |
| spc_shutdown | input | 1 | Shutdown special cycle observed |
| shutdown_hit | output | 1 | Shutdown special cycle recognised |
| serr_req | output | 1 | One-cycle system-error request |
| io_en | output | 1 | I/O space enable (fixed 1) |
| mem_en | output | 1 | Memory space enable (fixed 1) |
| bus_master_en | output | 1 | Bus master enable (fixed 1) |
| special_cycle_en | output | 1 | Command bit 3 |
| serr_en | output | 1 | Command bit 8 |

## Verification
The assertions assume that each event input is a pulse synchronous to `clk`, and that request fields stay steady while `req_valid` waits for `req_ready`. They also assume `rsp_ready` comes from a consumer that does not depend on `req_valid`. The stimulus meets these assumptions because every input changes shortly after a rising edge and keeps its value for at least one full cycle. A request is dropped only after the bench has seen `req_ready` high. Each event pulse lasts exactly one cycle. The only overlap the bench creates on purpose is a status clear and a set event in the same cycle.

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;
  localparam int DW    = 32;
  localparam int REG_W = DW / 2;
  localparam int BE_W  = DW / 8;
  localparam int N_EVT = 4;
  localparam logic [REG_W-1:0] CMD_CONST = 16'h0007;
  localparam logic [REG_W-1:0] STS_CONST = 16'h0280;
  localparam int CMD_SCE_BIT  = 3;
  localparam int CMD_SERR_BIT = 8;
  localparam int STS_EVT_LSB  = 11;
  // event order within the sticky field: 0 sent abort, 1 rcvd abort, 2 master abort, 3 serr
  typedef struct packed {
    logic serr;
    logic mabort;
    logic tabort_rcvd;
    logic tabort_sent;
  } sts_evt_t;
endpackage

// File: rtl/pci_cmd_reg.sv
module pci_cmd_reg
  import pci_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cmd_word,
  output logic             sce,
  output logic             serre
);
  logic sce_q, serre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sce_q   <= 1'b0;
      serre_q <= 1'b0;
    end else if (wr_en) begin
      if (be[CMD_SCE_BIT/8])  sce_q   <= wdata[CMD_SCE_BIT];
      if (be[CMD_SERR_BIT/8]) serre_q <= wdata[CMD_SERR_BIT];
    end
  end

  always_comb begin
    cmd_word               = CMD_CONST;
    cmd_word[CMD_SCE_BIT]  = sce_q;
    cmd_word[CMD_SERR_BIT] = serre_q;
  end

  assign sce   = sce_q;
  assign serre = serre_q;

  // R4: a write on one lane leaves the other lane's enable untouched
  a_r4_lane_independent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 2'b01) |=> $stable(serre_q));
endmodule

// File: rtl/pci_sts_reg.sv
module pci_sts_reg
  import pci_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic [N_EVT-1:0] evt_set,
  output logic [REG_W-1:0] sts_word
);
  logic [N_EVT-1:0] flag_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                       flag_q[i] <= 1'b0;
      else if (evt_set[i])              flag_q[i] <= 1'b1;
      else if (clr_en && clr_mask[i])   flag_q[i] <= 1'b0;
    end

    // R9: a set event is never lost, even under a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[i] |=> flag_q[i]);
    // R8: a 1 written with no competing event clears the flag
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_mask[i] && !evt_set[i]) |=> !flag_q[i]);
  end

  always_comb begin
    sts_word = STS_CONST;
    sts_word[STS_EVT_LSB +: N_EVT] = flag_q;
  end
endmodule

// File: rtl/pci_serr_gen.sv
module pci_serr_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic local_en,
  input  logic ext_en,
  output logic fire,
  output logic serr_pulse
);
  assign fire = timeout && local_en && ext_en;

  always_ff @(posedge clk) begin
    if (!rst_n) serr_pulse <= 1'b0;
    else        serr_pulse <= fire;
  end

  // R5: a request only ever follows a timeout
  a_r5_serr_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> $past(timeout));
endmodule

// File: rtl/pci_cmdsts_regs.sv
module pci_cmdsts_regs
  import pci_cs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [BE_W-1:0] req_be,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  input  logic            ev_master_abort,
  input  logic            ev_target_abort_rcvd,
  input  logic            ev_target_abort_sent,
  input  logic            dt_timeout,
  input  logic            serr_ext_en,
  input  logic            spc_shutdown,
  output logic            shutdown_hit,
  output logic            serr_req,
  output logic            io_en,
  output logic            mem_en,
  output logic            bus_master_en,
  output logic            special_cycle_en,
  output logic            serr_en
);
  logic             accept, wr_acc, rd_acc;
  logic [REG_W-1:0] cmd_word, sts_word;
  logic             sce, serre, serr_fire;
  sts_evt_t         evt;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_acc    = accept && !req_write;

  pci_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_acc),
    .be       (req_be[1:0]),
    .wdata    (req_wdata[REG_W-1:0]),
    .cmd_word (cmd_word),
    .sce      (sce),
    .serre    (serre)
  );

  pci_serr_gen u_serr (
    .clk        (clk),
    .rst_n      (rst_n),
    .timeout    (dt_timeout),
    .local_en   (serre),
    .ext_en     (serr_ext_en),
    .fire       (serr_fire),
    .serr_pulse (serr_req)
  );

  assign evt.serr        = serr_fire;
  assign evt.mabort      = ev_master_abort;
  assign evt.tabort_rcvd = ev_target_abort_rcvd;
  assign evt.tabort_sent = ev_target_abort_sent;

  pci_sts_reg u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr_acc && req_be[BE_W-1]),
    .clr_mask (req_wdata[REG_W+STS_EVT_LSB +: N_EVT]),
    .evt_set  (evt),
    .sts_word (sts_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= {sts_word, cmd_word};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign shutdown_hit     = spc_shutdown && sce;
  assign io_en            = cmd_word[0];
  assign mem_en           = cmd_word[1];
  assign bus_master_en    = cmd_word[2];
  assign special_cycle_en = sce;
  assign serr_en          = serre;

  // R6: every request to the bus is recorded in the status word
  a_r6_serr_logged: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> sts_word[STS_EVT_LSB+3]);
  // R11: a stalled response holds its data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R2: fixed enables never drop after reset
  a_r2_fixed_en: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && mem_en && bus_master_en));
endmodule

// File: tb/pci_cmdsts_regs_bench.sv
module pci_cmdsts_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic ev_ma = 0, ev_rta = 0, ev_sta = 0, dt_to = 0, ext_en = 0, spc = 0;
  logic req_ready, rsp_valid, shutdown_hit, serr_req;
  logic io_en, mem_en, bm_en, sc_en, se_en;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pci_cmdsts_regs u_pci_cmdsts_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ev_master_abort(ev_ma), .ev_target_abort_rcvd(ev_rta),
    .ev_target_abort_sent(ev_sta), .dt_timeout(dt_to), .serr_ext_en(ext_en),
    .spc_shutdown(spc), .shutdown_hit(shutdown_hit), .serr_req(serr_req),
    .io_en(io_en), .mem_en(mem_en), .bus_master_en(bm_en),
    .special_cycle_en(sc_en), .serr_en(se_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each response transfer
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected response", rsp_rdata, 32'hx);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic issue(logic wr, logic [3:0] be, logic [31:0] d);
    req_valid = 1; req_write = wr; req_be = be; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; req_be = '0;
  endtask

  task automatic rd(logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    issue(1'b0, 4'h0, 32'h0);
  endtask

  task automatic timeout_expect(logic exp, string tag);
    dt_to = 1; @(posedge clk); #1; dt_to = 0;
    @(negedge clk); check(tag, {31'b0, serr_req}, {31'b0, exp});
    @(negedge clk); check({tag, " one cycle"}, {31'b0, serr_req}, 32'h0);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check("R2 fixed enables", {29'b0, io_en, mem_en, bm_en}, 32'h7);
    @(posedge clk); #1;
    rd(32'h0280_0007, "R1 reset value");
    issue(1, 4'hF, 32'hFFFF_FFFF);
    rd(32'h0280_010F, "R2 R10 write ones");
    issue(1, 4'h1, 32'h0);
    rd(32'h0280_0107, "R4 lane0 only");
    issue(1, 4'h2, 32'h0);
    rd(32'h0280_0007, "R4 lane1 only");
    // R3 shutdown gating
    spc = 1; @(negedge clk); check("R3 shutdown disabled", {31'b0, shutdown_hit}, 32'h0);
    @(posedge clk); #1; spc = 0;
    issue(1, 4'h1, 32'h0000_0008);
    spc = 1; @(negedge clk); check("R3 shutdown enabled", {31'b0, shutdown_hit}, 32'h1);
    @(posedge clk); #1; spc = 0;
    // R5 gating
    ext_en = 1;
    timeout_expect(0, "R5 local enable off");
    issue(1, 4'h2, 32'h0000_0100);
    ext_en = 0;
    timeout_expect(0, "R5 external enable off");
    ext_en = 1;
    timeout_expect(1, "R5 both enabled");
    rd(32'h4280_010F, "R6 serr status");
    ev_ma = 1; ev_rta = 1; ev_sta = 1; @(posedge clk); #1;
    ev_ma = 0; ev_rta = 0; ev_sta = 0;
    rd(32'h7A80_010F, "R7 event flags");
    issue(1, 4'h4, 32'hFFFF_0000);
    rd(32'h7A80_010F, "R8 R10 lane2 write");
    issue(1, 4'h8, 32'h0);
    rd(32'h7A80_010F, "R8 zero write");
    issue(1, 4'h8, 32'h2800_0000);
    rd(32'h5280_010F, "R8 clear 13 and 11");
    ev_rta = 1; issue(1, 4'h8, 32'h1000_0000); ev_rta = 0;
    rd(32'h5280_010F, "R9 set beats clear");
    issue(1, 4'h8, 32'hFFFF_FFFF);
    // R11 back-pressure
    rsp_ready = 0;
    exp_q.push_back(32'h0280_010F); tag_q.push_back("R11 stalled read");
    issue(0, 4'h0, 32'h0);
    @(negedge clk);
    check("R11 valid", {31'b0, rsp_valid}, 32'h1);
    check("R11 ready low", {31'b0, req_ready}, 32'h0);
    held = rsp_rdata;
    @(negedge clk);
    check("R11 data held", rsp_rdata, held);
    @(posedge clk); #1; rsp_ready = 1;
    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule